// File: doc/BRIEF.md
# Serial Channel Interrupt Source Aggregator

This block gathers the interrupt-worthy events of one serial channel into four request lines: receive status, receive data, transmit status and transmit data. Each status event arrives as a one-cycle pulse. The pulse latches into a sticky pending bit. That bit stays set until software acknowledges it by writing a one to its clear input. A pending bit reaches its group's request line only while the arm bit for that source is set. Software can therefore enable a source after the event and still see it.

The two data requests follow the FIFO fill levels. The receive data request is raised while the receive FIFO holds more entries than its programmed threshold. The transmit data request is raised while the transmit FIFO holds fewer entries than its own threshold. Both data requests are level-sensitive and need no acknowledge.

The six receive status sources sit at these bit positions of the receive vectors:
- bit 0: leaving hunt
- bit 1: idle line detected
- bit 2: break or abort detected
- bit 3: code violation or end of message
- bit 4: parity error or abort
- bit 5: overrun

The six transmit status sources sit at these bit positions of the transmit vectors:
- bit 0: preamble done
- bit 1: idle sent
- bit 2: abort sent
- bit 3: end of frame or message sent
- bit 4: CRC sent
- bit 5: underrun

Top module: `sia_irq_aggregator`

## Requirements
- R1: While rst_n is low and in the first cycle after it, both pending vectors read zero and all four request outputs are low.
- R2: An event pulse on bit i of rx_evt or tx_evt sets bit i of the matching pending vector at the next rising clock edge, whatever the arm bit holds.
- R3: A set pending bit stays set until a one is presented on its bit of rx_clr or tx_clr. That clear takes effect at the next edge and leaves every other bit unchanged.
- R4: When an event and a clear hit the same bit in the same cycle, the bit is set after the edge.
- R5: rx_stat_irq equals the OR over all six bits of (rx_pend AND rx_arm), in the same cycle with no register in between. tx_stat_irq is formed the same way from tx_pend and tx_arm.
- R6: rx_data_irq is high in the cycle after an edge at which rx_level was greater than rx_thresh, and low otherwise, with no acknowledge needed.
- R7: tx_data_irq is high in the cycle after an edge at which tx_level was less than tx_thresh, and low otherwise, with no acknowledge needed.
- R8: Equal level and threshold raise neither data request. A transmit threshold of 0 and a receive threshold of 31 can never raise their data request.
- R9: Receive inputs never change transmit pending bits or requests, and transmit inputs never change receive pending bits or requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_evt | input | 6 | Receive status event pulses |
| rx_arm | input | 6 | Receive status arm bits |
| rx_clr | input | 6 | Receive pending write-one-to-clear |
| tx_evt | input | 6 | Transmit status event pulses |
| tx_arm | input | 6 | Transmit status arm bits |
| tx_clr | input | 6 | Transmit pending write-one-to-clear |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_thresh | input | 5 | Receive data threshold |
| tx_level | input | 5 | Transmit FIFO fill level |
| tx_thresh | input | 5 | Transmit data threshold |
| rx_pend | output | 6 | Receive status pending bits |
| tx_pend | output | 6 | Transmit status pending bits |
| rx_stat_irq | output | 1 | Receive status request |
| tx_stat_irq | output | 1 | Transmit status request |
| rx_data_irq | output | 1 | Receive data request |
| tx_data_irq | output | 1 | Transmit data request |

## Verification
Several stimulus patterns are applied, and each one separates a different kind of fault:
- An event with its arm bit low, followed later by arming, shows whether latching has been wrongly tied to the arm bit.
- A coincident event and clear on one bit shows which of the two wins.
- A clear on a single bit among several pending bits catches clears that spill onto neighbouring bits.
- Level sweeps through threshold minus one, threshold and threshold plus one, including thresholds 0 and 31, tell a strict comparison from an inclusive or reversed one.
- A long pseudo-random mix of events, clears, arms and levels, compared every cycle with a behavioural model, catches crosstalk between the receive and transmit groups.

// File: rtl/sia_pkg.sv
package sia_pkg;

  localparam int SRC_N = 6;
  localparam int LVL_W = 5;

  // receive status bit positions
  typedef enum int {
    RXS_HUNT_EXIT = 0,
    RXS_IDLE      = 1,
    RXS_BREAK     = 2,
    RXS_CODE_EOM  = 3,
    RXS_PARITY    = 4,
    RXS_OVERRUN   = 5
  } rx_src_e;

  // transmit status bit positions
  typedef enum int {
    TXS_PREAMBLE  = 0,
    TXS_IDLE      = 1,
    TXS_ABORT     = 2,
    TXS_EOF       = 3,
    TXS_CRC       = 4,
    TXS_UNDERRUN  = 5
  } tx_src_e;

  // next pending value: an event wins over a clear
  function automatic logic [31:0] pend_next(input logic [31:0] cur,
                                            input logic [31:0] evt,
                                            input logic [31:0] clr);
    return (cur & ~clr) | evt;
  endfunction

  // true if any pending source is also armed
  function automatic logic any_armed(input logic [31:0] pend,
                                     input logic [31:0] arm);
    return |(pend & arm);
  endfunction

  // receive side: strictly above threshold
  function automatic logic lvl_above(input logic [31:0] lvl,
                                     input logic [31:0] thr);
    return lvl > thr;
  endfunction

  // transmit side: strictly below threshold
  function automatic logic lvl_below(input logic [31:0] lvl,
                                     input logic [31:0] thr);
    return lvl < thr;
  endfunction

endpackage

// File: rtl/sia_status_group.sv
module sia_status_group #(
  parameter int NSRC = sia_pkg::SRC_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] arm,
  output logic [NSRC-1:0] pend,
  output logic            req
);
  import sia_pkg::*;

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [31:0]     next_w;

  assign next_w = pend_next(32'(pend_q), 32'(evt), 32'(clr));
  assign pend_d = next_w[NSRC-1:0];

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end

  assign pend = pend_q;
  assign req  = any_armed(32'(pend_q), 32'(arm));

endmodule

// File: rtl/sia_level_req.sv
module sia_level_req #(
  parameter int LW    = sia_pkg::LVL_W,
  parameter bit ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lvl,
  input  logic [LW-1:0] thr,
  output logic          req
);
  import sia_pkg::*;

  logic hit_w;

  if (ABOVE) begin : g_above
    assign hit_w = lvl_above(32'(lvl), 32'(thr));
  end else begin : g_below
    assign hit_w = lvl_below(32'(lvl), 32'(thr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= hit_w;
  end

endmodule

// File: rtl/sia_irq_aggregator.sv
module sia_irq_aggregator #(
  parameter int NSRC = sia_pkg::SRC_N,
  parameter int LW   = sia_pkg::LVL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rx_evt,
  input  logic [NSRC-1:0] rx_arm,
  input  logic [NSRC-1:0] rx_clr,
  input  logic [NSRC-1:0] tx_evt,
  input  logic [NSRC-1:0] tx_arm,
  input  logic [NSRC-1:0] tx_clr,
  input  logic [LW-1:0]   rx_level,
  input  logic [LW-1:0]   rx_thresh,
  input  logic [LW-1:0]   tx_level,
  input  logic [LW-1:0]   tx_thresh,
  output logic [NSRC-1:0] rx_pend,
  output logic [NSRC-1:0] tx_pend,
  output logic            rx_stat_irq,
  output logic            tx_stat_irq,
  output logic            rx_data_irq,
  output logic            tx_data_irq
);

  // named internal wires, visible to the bound checker
  logic            rx_stat_w, tx_stat_w, rx_data_w, tx_data_w;
  logic [NSRC-1:0] rx_pend_w, tx_pend_w;

  sia_status_group #(.NSRC(NSRC)) u_rx_stat (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt), .clr(rx_clr), .arm(rx_arm),
    .pend(rx_pend_w), .req(rx_stat_w)
  );

  sia_status_group #(.NSRC(NSRC)) u_tx_stat (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt), .clr(tx_clr), .arm(tx_arm),
    .pend(tx_pend_w), .req(tx_stat_w)
  );

  sia_level_req #(.LW(LW), .ABOVE(1'b1)) u_rx_data (
    .clk(clk), .rst_n(rst_n), .lvl(rx_level), .thr(rx_thresh), .req(rx_data_w)
  );

  sia_level_req #(.LW(LW), .ABOVE(1'b0)) u_tx_data (
    .clk(clk), .rst_n(rst_n), .lvl(tx_level), .thr(tx_thresh), .req(tx_data_w)
  );

  assign rx_pend     = rx_pend_w;
  assign tx_pend     = tx_pend_w;
  assign rx_stat_irq = rx_stat_w;
  assign tx_stat_irq = tx_stat_w;
  assign rx_data_irq = rx_data_w;
  assign tx_data_irq = tx_data_w;

endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
  parameter int NSRC = sia_pkg::SRC_N,
  parameter int LW   = sia_pkg::LVL_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] rx_evt,
  input logic [NSRC-1:0] rx_arm,
  input logic [NSRC-1:0] rx_clr,
  input logic [NSRC-1:0] tx_evt,
  input logic [NSRC-1:0] tx_arm,
  input logic [NSRC-1:0] tx_clr,
  input logic [LW-1:0]   rx_level,
  input logic [LW-1:0]   rx_thresh,
  input logic [LW-1:0]   tx_level,
  input logic [LW-1:0]   tx_thresh,
  input logic [NSRC-1:0] rx_pend,
  input logic [NSRC-1:0] tx_pend,
  input logic            rx_stat_irq,
  input logic            tx_stat_irq,
  input logic            rx_data_irq,
  input logic            tx_data_irq
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  rx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (rx_evt != '0) |=> ((rx_pend & $past(rx_evt)) == $past(rx_evt)));

  // R3
  rx_clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && ((rx_clr & ~rx_evt) != '0) |=> ((rx_pend & $past(rx_clr & ~rx_evt)) == '0));

  // R3
  tx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((tx_pend & $past(tx_pend & ~tx_clr)) == $past(tx_pend & ~tx_clr)));

  // R9
  tx_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((tx_pend & ~$past(tx_pend | tx_evt)) == '0));

  // R5
  rx_stat_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stat_irq == (|(rx_pend & rx_arm)));

  // R5
  tx_stat_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stat_irq == (|(tx_pend & tx_arm)));

  // R6
  rx_data_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (rx_data_irq == ($past(rx_level) > $past(rx_thresh))));

  // R7
  tx_data_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (tx_data_irq == ($past(tx_level) < $past(tx_thresh))));

endmodule

bind sia_irq_aggregator sia_checker #(.NSRC(NSRC), .LW(LW)) u_chk (.*);

// File: tb/sim_sia_irq_aggregator.sv
`timescale 1ns/1ps
module sim_sia_irq_aggregator;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rx_evt = '0, rx_arm = '0, rx_clr = '0;
  logic [N-1:0] tx_evt = '0, tx_arm = '0, tx_clr = '0;
  logic [4:0] rx_level = '0, rx_thresh = '0, tx_level = '0, tx_thresh = '0;
  logic [N-1:0] rx_pend, tx_pend;
  logic rx_stat_irq, tx_stat_irq, rx_data_irq, tx_data_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural model state
  bit m_rxp[N];
  bit m_txp[N];
  bit m_rxd, m_txd;

  always #4 clk = ~clk;   // 125 MHz

  sia_irq_aggregator u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pack(input bit v[N]);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r += (1 << i);
    return r;
  endfunction

  function automatic int armed_any(input bit v[N], input logic [N-1:0] a);
    for (int i = 0; i < N; i++) if (v[i] && a[i]) return 1;
    return 0;
  endfunction

  // compare all outputs against the model
  task automatic compare_all();
    chk("R2/R3/R4 rx_pend", int'(rx_pend), pack(m_rxp));
    chk("R2/R3/R9 tx_pend", int'(tx_pend), pack(m_txp));
    chk("R5 rx_stat_irq", int'(rx_stat_irq), armed_any(m_rxp, rx_arm));
    chk("R5 tx_stat_irq", int'(tx_stat_irq), armed_any(m_txp, tx_arm));
    chk("R6 rx_data_irq", int'(rx_data_irq), int'(m_rxd));
    chk("R7 tx_data_irq", int'(tx_data_irq), int'(m_txd));
  endtask

  // one clock: update model from current inputs, advance, compare
  task automatic step();
    bit nrx[N];
    bit ntx[N];
    bit nrd, ntd;
    for (int i = 0; i < N; i++) begin
      nrx[i] = rx_evt[i] ? 1'b1 : (rx_clr[i] ? 1'b0 : m_rxp[i]);
      ntx[i] = tx_evt[i] ? 1'b1 : (tx_clr[i] ? 1'b0 : m_txp[i]);
    end
    nrd = int'(rx_level) > int'(rx_thresh);
    ntd = int'(tx_level) < int'(tx_thresh);
    @(posedge clk);
    if (rst_n) begin
      m_rxp = nrx; m_txp = ntx; m_rxd = nrd; m_txd = ntd;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    rx_evt = '0; rx_clr = '0; tx_evt = '0; tx_clr = '0;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..all act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    for (int i = 0; i < N; i++) begin m_rxp[i] = 0; m_txp[i] = 0; end
    m_rxd = 0; m_txd = 0;
    rx_level = 5'd20; rx_thresh = 5'd3; tx_level = 5'd0; tx_thresh = 5'd9;
    rx_arm = '1; tx_arm = '1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything low despite level conditions
    chk("R1 rx_pend reset", int'(rx_pend), 0);
    chk("R1 data irqs reset", int'({rx_data_irq, tx_data_irq}), 0);
    rst_n = 1'b1;
    // first cycle after reset: registers still show reset values
    chk("R1 stat irqs after reset", int'({rx_stat_irq, tx_stat_irq}), 0);
    chk("R1 rx_data_irq after reset", int'(rx_data_irq), 0);
    rx_level = 0; rx_thresh = 0; tx_level = 0; tx_thresh = 0;
    rx_arm = '0; tx_arm = '0;
    step();

    // R2: unarmed event latches but does not request
    rx_evt = 6'b000100; step(); quiet();
    chk("R2 unarmed latch", int'(rx_pend), 4);
    chk("R5 unarmed no req", int'(rx_stat_irq), 0);
    step();
    rx_arm = 6'b000100; #1;
    chk("R5 late arm raises req", int'(rx_stat_irq), 1);
    step();

    // R3: clearing one bit leaves the other
    rx_evt = 6'b100001; step(); quiet();
    rx_clr = 6'b000100; step(); quiet();
    chk("R3 single clear", int'(rx_pend), 6'b100001);
    rx_clr = 6'b000001; step(); quiet();
    chk("R3 clear keeps others", int'(rx_pend), 6'b100000);

    // R4: simultaneous event and clear on bit 5
    rx_clr = 6'b100000; rx_evt = 6'b100000; step(); quiet();
    chk("R4 event beats clear", int'(rx_pend[5]), 1);
    rx_clr = 6'b100000; step(); quiet();
    chk("R3 final clear", int'(rx_pend), 0);

    // R9: receive activity does not touch transmit side
    tx_arm = '1;
    rx_evt = '1; step(); quiet();
    chk("R9 tx_pend untouched", int'(tx_pend), 0);
    chk("R9 tx_stat untouched", int'(tx_stat_irq), 0);
    tx_evt = 6'b010010; step(); quiet();
    chk("R9 rx_pend untouched", int'(rx_pend), 6'b111111);
    chk("R2 tx latch", int'(tx_pend), 6'b010010);
    rx_clr = '1; tx_clr = '1; step(); quiet();

    // R6/R8: receive threshold sweep
    rx_thresh = 10;
    rx_level = 9;  step(); chk("R8 rx below", int'(rx_data_irq), 0);
    rx_level = 10; step(); chk("R8 rx equal", int'(rx_data_irq), 0);
    rx_level = 11; step(); chk("R6 rx above", int'(rx_data_irq), 1);
    rx_level = 4;  step(); chk("R6 rx drops w/o ack", int'(rx_data_irq), 0);
    rx_thresh = 31; rx_level = 31; step(); chk("R8 rx thresh 31", int'(rx_data_irq), 0);

    // R7/R8: transmit threshold sweep
    tx_thresh = 10;
    tx_level = 11; step(); chk("R8 tx above", int'(tx_data_irq), 0);
    tx_level = 10; step(); chk("R8 tx equal", int'(tx_data_irq), 0);
    tx_level = 9;  step(); chk("R7 tx below", int'(tx_data_irq), 1);
    tx_level = 30; step(); chk("R7 tx drops w/o ack", int'(tx_data_irq), 0);
    tx_thresh = 0; tx_level = 0; step(); chk("R8 tx thresh 0", int'(tx_data_irq), 0);

    // mixed pseudo-random traffic against the model
    lfsr = 32'h1ACE_B00C;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rx_evt = lfsr[5:0] & {6{lfsr[30]}};
      tx_evt = lfsr[11:6] & {6{lfsr[29]}};
      rx_clr = lfsr[17:12] & {6{lfsr[28]}};
      tx_clr = lfsr[23:18] & {6{lfsr[27]}};
      if (lfsr[26]) begin rx_arm = lfsr[8:3]; tx_arm = lfsr[20:15]; end
      rx_level = lfsr[24:20]; tx_level = lfsr[13:9];
      if (c % 50 == 0) begin rx_thresh = lfsr[31:27]; tx_thresh = lfsr[4:0]; end
      step();
    end
    quiet();
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule